// File: doc/BRIEF.md
# SCSI Control Register and Interrupt Block

This block is the host-facing control register file of a parallel SCSI bus interface. A host reads and writes 8-bit registers through a chip select, an address and a write strobe. The registers pick the device role (initiator or target), set which bus lines are driven, and turn each interrupt source on or off. The block drives a bus reset line and a set of drive enables for the bus lines. Each drive enable is gated by the current role. The block also collects three interrupt conditions into one sticky request: an unexpected drop of the bus busy line, an end-of-process pulse from the DMA side, and a detected parity error.

A reset command bit in the command register asserts the bus reset line. While that bit is set, every other piece of control state is held cleared. Only the reset bit and the interrupt latch keep their values. When busy monitoring is on and busy drops, the block releases the bus on its own and clears the lower command bits. Phase sequencing, arbitration timing and the DMA handshake are handled by other blocks.

Top module: `scsi_ctrl_regs`

## Requirements
- R1: The mode register is at address 2. All eight bits are read back exactly as written. Bit 0 is arbitrate, 1 DMA enable, 2 busy monitor, 3 end-of-process interrupt enable, 4 parity interrupt enable, 5 parity check enable, 6 target role, 7 block DMA. A read at an address with no register (0, 4 to 7) returns 0, and `host_rdata` is 0 while `host_cs` is low.
- R2: The command register is at address 1. Bit 0 drives the data bus, bit 1 attention, bit 2 select, bit 3 busy, bit 4 acknowledge, and bit 7 is the bus reset command. Bits 5 and 6 always read 0. The target signal register is at address 3: bit 0 input/output, bit 1 control/data, bit 2 message, bit 3 request. Its bits 7:4 read 0.
- R3: Writing 1 to command bit 7 asserts `bus_rst_o` after that clock edge and sets the interrupt latch. `bus_rst_o` stays high until bit 7 is written to 0 or `rst_n` is asserted.
- R4: While command bit 7 is set, including the edge that sets it, the mode register, the target register, command bits 6:0 and the parity latch read as 0, and host writes to them are ignored. The interrupt latch is not changed by this clearing.
- R5: With the busy monitor bit set, a bus busy input that was 1 at one edge and is 0 at the next sets the interrupt latch at that edge. The same edge clears command bits 5:0 and the target register, and every drive output goes low. With the monitor bit clear, a busy drop has no effect.
- R6: An end-of-process pulse sets the interrupt latch only when the end-of-process interrupt enable is set.
- R7: With parity checking off, a parity error input is ignored. With it on, the error sets the parity latch (`par_err_o`). It sets the interrupt latch only when the parity interrupt enable is also on.
- R8: The interrupt latch and the parity latch stay set until a `host_irq_clr` pulse clears them. If a source fires in the same cycle as the clear, the latch stays set.
- R9: With target role 0, only attention and acknowledge follow their command bits, and control/data, input/output, message and request stay low. With target role 1 it is the other way round. The data, select and busy drives ignore the role.
- R10: All drive outputs and `bus_rst_o` are registers. They change on the same clock edge as the register write that controls them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Register access select |
| host_we | input | 1 | Write strobe, qualified by host_cs |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| host_irq_clr | input | 1 | Clears the interrupt and parity latches |
| bus_bsy_i | input | 1 | Sampled bus busy, 1 = asserted |
| dma_eop_i | input | 1 | End-of-process pulse from the DMA side |
| par_err_i | input | 1 | Parity error detected on the current byte |
| irq_o | output | 1 | Sticky interrupt request |
| par_err_o | output | 1 | Parity error latch |
| bus_rst_o | output | 1 | Drive bus reset |
| drv_data_o | output | 1 | Drive data bus |
| drv_atn_o | output | 1 | Drive attention |
| drv_sel_o | output | 1 | Drive select |
| drv_bsy_o | output | 1 | Drive busy |
| drv_ack_o | output | 1 | Drive acknowledge |
| drv_io_o | output | 1 | Drive input/output |
| drv_cd_o | output | 1 | Drive control/data |
| drv_msg_o | output | 1 | Drive message |
| drv_req_o | output | 1 | Drive request |

## Verification
The assertions assume that `bus_bsy_i`, `dma_eop_i` and `par_err_i` are already synchronous to `clk`, so that one busy sample per edge is a real bus level and a busy drop is a one-edge event. They also assume that the host holds address and data stable across the edge where a write takes place. The stimulus changes every input only on the falling clock edge. The busy line toggles rarely, so that both monitored and unmonitored drops occur, and a reset command is written rarely, so that the frozen state is entered and left many times.

// File: rtl/scsi_ctrl_pkg.sv
package scsi_ctrl_pkg;

  localparam int REG_W     = 8;
  localparam int CMD_LOW_W = 6;

  // mode register, bit 7 down to bit 0
  typedef struct packed {
    logic blk_dma;
    logic target;
    logic par_chk;
    logic par_irq_en;
    logic eop_irq_en;
    logic mon_bsy;
    logic dma_en;
    logic arb;
  } mode_t;

  // command register, bit 7 down to bit 0
  typedef struct packed {
    logic       bus_rst;
    logic [1:0] rsvd;
    logic       ack;
    logic       bsy;
    logic       sel;
    logic       atn;
    logic       data;
  } cmd_t;

  // target signal register, bit 7 down to bit 0
  typedef struct packed {
    logic [3:0] rsvd;
    logic       req;
    logic       msg;
    logic       cd;
    logic       io;
  } tgt_t;

endpackage

// File: rtl/scsi_ctrl_regfile.sv
module scsi_ctrl_regfile
  import scsi_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CMD_ADDR  = 1,
  parameter int MODE_ADDR = 2,
  parameter int TGT_ADDR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  input  logic              busy_lost_i,
  output mode_t             mode_q,
  output cmd_t              cmd_q,
  output tgt_t              tgt_q,
  output mode_t             mode_d,
  output cmd_t              cmd_d,
  output tgt_t              tgt_d,
  output logic              hold_o,
  output logic              rst_rise_o
);

  logic wr_en;
  logic rst_bit_d;

  assign wr_en = host_cs & host_we;

  always_comb begin
    mode_d    = mode_q;
    cmd_d     = cmd_q;
    tgt_d     = tgt_q;
    if (wr_en && host_addr == ADDR_W'(CMD_ADDR)) begin
      cmd_d      = cmd_t'(host_wdata);
      cmd_d.rsvd = '0;
    end
    if (wr_en && host_addr == ADDR_W'(MODE_ADDR)) begin
      mode_d = mode_t'(host_wdata);
    end
    if (wr_en && host_addr == ADDR_W'(TGT_ADDR)) begin
      tgt_d      = tgt_t'(host_wdata);
      tgt_d.rsvd = '0;
    end
    if (busy_lost_i) begin
      cmd_d[CMD_LOW_W-1:0] = '0;
      tgt_d                = '0;
    end
    rst_bit_d = cmd_d.bus_rst;
    hold_o    = cmd_q.bus_rst | rst_bit_d;
    if (hold_o) begin
      mode_d        = '0;
      tgt_d         = '0;
      cmd_d         = '0;
      cmd_d.bus_rst = rst_bit_d;
    end
  end

  assign rst_rise_o = cmd_d.bus_rst & ~cmd_q.bus_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmd_q  <= '0;
      tgt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cmd_q  <= cmd_d;
      tgt_q  <= tgt_d;
    end
  end

  // R4: reset command freezes all other control state at zero
  a_r4_reset_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.bus_rst |-> (mode_q == '0 && tgt_q == '0 && cmd_q[REG_W-2:0] == '0));

  // R5: a busy drop under monitoring strips low command bits and target drives
  a_r5_busy_loss_strips: assert property (@(posedge clk) disable iff (!rst_n)
    busy_lost_i |=> (cmd_q[CMD_LOW_W-1:0] == '0 && tgt_q == '0));

  // R2: reserved bits never hold a one
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q.rsvd == '0 && tgt_q.rsvd == '0));

endmodule

// File: rtl/scsi_ctrl_irq.sv
module scsi_ctrl_irq
  import scsi_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_i,
  input  logic  bsy_i,
  input  logic  eop_i,
  input  logic  par_i,
  input  logic  clr_i,
  input  logic  hold_i,
  input  logic  rst_rise_i,
  output logic  busy_lost_o,
  output logic  irq_o,
  output logic  par_o
);

  logic bsy_q;
  logic irq_q, irq_d;
  logic par_q, par_d;
  logic src_set;
  logic par_hit;

  assign busy_lost_o = mode_i.mon_bsy & bsy_q & ~bsy_i;
  assign par_hit     = mode_i.par_chk & par_i;
  assign src_set     = rst_rise_i | busy_lost_o
                     | (mode_i.eop_irq_en & eop_i)
                     | (mode_i.par_irq_en & par_hit);

  always_comb begin
    irq_d = src_set | (irq_q & ~clr_i);
    par_d = par_hit | (par_q & ~clr_i);
    if (hold_i) begin
      par_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_q <= 1'b0;
      irq_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      bsy_q <= bsy_i;
      irq_q <= irq_d;
      par_q <= par_d;
    end
  end

  assign irq_o = irq_q;
  assign par_o = par_q;

  // R3: setting the reset command raises the interrupt
  a_r3_rst_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rise_i |=> irq_q);

  // R7: the parity latch only rises when checking was enabled
  a_r7_par_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_q) |-> $past(mode_i.par_chk));

  // R8: a clear with no source leaves the latch low
  a_r8_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !src_set) |=> !irq_q);

  // R8: the latch holds without a clear
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_i) |=> irq_q);

endmodule

// File: rtl/scsi_ctrl_drive.sv
module scsi_ctrl_drive
  import scsi_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_d,
  input  cmd_t  cmd_d,
  input  tgt_t  tgt_d,
  output logic  bus_rst_o,
  output logic  drv_data_o,
  output logic  drv_atn_o,
  output logic  drv_sel_o,
  output logic  drv_bsy_o,
  output logic  drv_ack_o,
  output logic  drv_io_o,
  output logic  drv_cd_o,
  output logic  drv_msg_o,
  output logic  drv_req_o
);

  logic init_en, targ_en;

  assign init_en = ~mode_d.target;
  assign targ_en = mode_d.target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rst_o  <= 1'b0;
      drv_data_o <= 1'b0;
      drv_atn_o  <= 1'b0;
      drv_sel_o  <= 1'b0;
      drv_bsy_o  <= 1'b0;
      drv_ack_o  <= 1'b0;
      drv_io_o   <= 1'b0;
      drv_cd_o   <= 1'b0;
      drv_msg_o  <= 1'b0;
      drv_req_o  <= 1'b0;
    end else begin
      bus_rst_o  <= cmd_d.bus_rst;
      drv_data_o <= cmd_d.data;
      drv_sel_o  <= cmd_d.sel;
      drv_bsy_o  <= cmd_d.bsy;
      drv_atn_o  <= init_en & cmd_d.atn;
      drv_ack_o  <= init_en & cmd_d.ack;
      drv_io_o   <= targ_en & tgt_d.io;
      drv_cd_o   <= targ_en & tgt_d.cd;
      drv_msg_o  <= targ_en & tgt_d.msg;
      drv_req_o  <= targ_en & tgt_d.req;
    end
  end

endmodule

// File: rtl/scsi_ctrl_regs.sv
module scsi_ctrl_regs
  import scsi_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CMD_ADDR  = 1,
  parameter int MODE_ADDR = 2,
  parameter int TGT_ADDR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              host_irq_clr,
  input  logic              bus_bsy_i,
  input  logic              dma_eop_i,
  input  logic              par_err_i,
  output logic              irq_o,
  output logic              par_err_o,
  output logic              bus_rst_o,
  output logic              drv_data_o,
  output logic              drv_atn_o,
  output logic              drv_sel_o,
  output logic              drv_bsy_o,
  output logic              drv_ack_o,
  output logic              drv_io_o,
  output logic              drv_cd_o,
  output logic              drv_msg_o,
  output logic              drv_req_o
);

  mode_t mode_q, mode_d;
  cmd_t  cmd_q, cmd_d;
  tgt_t  tgt_q, tgt_d;
  logic  hold, rst_rise, busy_lost;

  scsi_ctrl_regfile #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR),
    .MODE_ADDR(MODE_ADDR), .TGT_ADDR(TGT_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .busy_lost_i(busy_lost),
    .mode_q(mode_q), .cmd_q(cmd_q), .tgt_q(tgt_q),
    .mode_d(mode_d), .cmd_d(cmd_d), .tgt_d(tgt_d),
    .hold_o(hold), .rst_rise_o(rst_rise)
  );

  scsi_ctrl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q),
    .bsy_i(bus_bsy_i), .eop_i(dma_eop_i), .par_i(par_err_i),
    .clr_i(host_irq_clr), .hold_i(hold), .rst_rise_i(rst_rise),
    .busy_lost_o(busy_lost), .irq_o(irq_o), .par_o(par_err_o)
  );

  scsi_ctrl_drive u_drv (
    .clk(clk), .rst_n(rst_n),
    .mode_d(mode_d), .cmd_d(cmd_d), .tgt_d(tgt_d),
    .bus_rst_o(bus_rst_o), .drv_data_o(drv_data_o),
    .drv_atn_o(drv_atn_o), .drv_sel_o(drv_sel_o),
    .drv_bsy_o(drv_bsy_o), .drv_ack_o(drv_ack_o),
    .drv_io_o(drv_io_o), .drv_cd_o(drv_cd_o),
    .drv_msg_o(drv_msg_o), .drv_req_o(drv_req_o)
  );

  always_comb begin
    host_rdata = '0;
    if (host_cs) begin
      if (host_addr == ADDR_W'(CMD_ADDR))  host_rdata = cmd_q;
      if (host_addr == ADDR_W'(MODE_ADDR)) host_rdata = mode_q;
      if (host_addr == ADDR_W'(TGT_ADDR))  host_rdata = tgt_q;
    end
  end

  // R9: initiator-only drives never active in target role
  a_r9_init_drives_role: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_atn_o || drv_ack_o) |-> !mode_q.target);

  // R9: target-only drives never active in initiator role
  a_r9_targ_drives_role: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_io_o || drv_cd_o || drv_msg_o || drv_req_o) |-> mode_q.target);

  // R10: bus reset output tracks the stored command bit
  a_r10_rst_out_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_o == cmd_q.bus_rst);

endmodule

// File: tb/scsi_ctrl_regs_tb.sv
module scsi_ctrl_regs_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs, host_we, host_irq_clr;
  logic [2:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       bus_bsy_i, dma_eop_i, par_err_i;
  logic       irq_o, par_err_o, bus_rst_o;
  logic       drv_data_o, drv_atn_o, drv_sel_o, drv_bsy_o, drv_ack_o;
  logic       drv_io_o, drv_cd_o, drv_msg_o, drv_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [7:0] m_mode, m_cmd, m_tgt;
  logic       m_irq, m_par, m_bsy;

  always #5 clk = ~clk;

  scsi_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq_clr(host_irq_clr),
    .bus_bsy_i(bus_bsy_i), .dma_eop_i(dma_eop_i), .par_err_i(par_err_i),
    .irq_o(irq_o), .par_err_o(par_err_o), .bus_rst_o(bus_rst_o),
    .drv_data_o(drv_data_o), .drv_atn_o(drv_atn_o), .drv_sel_o(drv_sel_o),
    .drv_bsy_o(drv_bsy_o), .drv_ack_o(drv_ack_o), .drv_io_o(drv_io_o),
    .drv_cd_o(drv_cd_o), .drv_msg_o(drv_msg_o), .drv_req_o(drv_req_o)
  );

  function automatic logic [7:0] exp_rdata(input logic cs, input logic [2:0] a);
    if (!cs)        return 8'h00;
    if (a == 3'd1)  return m_cmd;
    if (a == 3'd2)  return m_mode;
    if (a == 3'd3)  return m_tgt;
    return 8'h00;
  endfunction

  // drive vector: {rst, data, atn, sel, bsy, ack, io, cd, msg, req}
  function automatic logic [9:0] exp_drv();
    logic t;
    t = m_mode[6];
    return {m_cmd[7], m_cmd[0], ~t & m_cmd[1], m_cmd[2], m_cmd[3], ~t & m_cmd[4],
            t & m_tgt[0], t & m_tgt[1], t & m_tgt[2], t & m_tgt[3]};
  endfunction

  // advance the reference by one clock edge using the current inputs
  task automatic model_step();
    logic [7:0] nm, nc, nt;
    logic lost, hold, rise, set, psetv;
    nm = m_mode; nc = m_cmd; nt = m_tgt;
    lost = m_mode[2] & m_bsy & ~bus_bsy_i;
    if (host_cs && host_we) begin
      if (host_addr == 3'd1) nc = host_wdata & 8'h9F;
      if (host_addr == 3'd2) nm = host_wdata;
      if (host_addr == 3'd3) nt = host_wdata & 8'h0F;
    end
    if (lost) begin nc[5:0] = 6'h0; nt = 8'h0; end
    hold = m_cmd[7] | nc[7];
    rise = nc[7] & ~m_cmd[7];
    if (hold) begin nm = 8'h0; nt = 8'h0; nc = {nc[7], 7'h0}; end
    psetv = m_mode[5] & par_err_i;
    set = rise | lost | (m_mode[3] & dma_eop_i) | (m_mode[4] & psetv);
    m_irq = set | (m_irq & ~host_irq_clr);
    m_par = hold ? 1'b0 : (psetv | (m_par & ~host_irq_clr));
    m_bsy = bus_bsy_i;
    m_mode = nm; m_cmd = nc; m_tgt = nt;
  endtask

  task automatic check_all(input string req);
    logic [9:0] got, exp;
    got = {bus_rst_o, drv_data_o, drv_atn_o, drv_sel_o, drv_bsy_o, drv_ack_o,
           drv_io_o, drv_cd_o, drv_msg_o, drv_req_o};
    exp = exp_drv();
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s drives: actual %b expected %b", req, got, exp);
    end
    checks++;
    if (irq_o !== m_irq || par_err_o !== m_par) begin
      fails++;
      $display("FAIL %s irq/par: actual %b%b expected %b%b", req, irq_o, par_err_o, m_irq, m_par);
    end
    checks++;
    if (host_rdata !== exp_rdata(host_cs, host_addr)) begin
      fails++;
      $display("FAIL %s rdata: actual %h expected %h", req, host_rdata,
               exp_rdata(host_cs, host_addr));
    end
  endtask

  // one clock: inputs already set at the falling edge
  task automatic tick(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(req);
  endtask

  task automatic idle_inputs();
    host_cs = 1'b0; host_we = 1'b0; host_addr = 3'd0; host_wdata = 8'h00;
    host_irq_clr = 1'b0; dma_eop_i = 1'b0; par_err_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
    idle_inputs();
    host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    tick(req);
    idle_inputs();
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    idle_inputs();
    host_cs = 1'b1; host_addr = a;
    tick(req);
    idle_inputs();
  endtask

  task automatic clr_irq(input string req);
    idle_inputs();
    host_irq_clr = 1'b1;
    tick(req);
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd5380));
    idle_inputs();
    bus_bsy_i = 1'b0;
    rst_n = 1'b0;
    m_mode = 8'h0; m_cmd = 8'h0; m_tgt = 8'h0;
    m_irq = 1'b0; m_par = 1'b0; m_bsy = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: mode readback and unmapped reads
    wr(3'd2, 8'hA5, "R1 mode write");
    rd(3'd2, "R1 mode readback");
    rd(3'd5, "R1 unmapped read");
    wr(3'd2, 8'h00, "R1 mode clear");

    // R2/R9/R10: initiator drives, reserved bits masked
    wr(3'd1, 8'h7F, "R2 cmd write reserved masked");
    rd(3'd1, "R2 cmd readback");
    wr(3'd3, 8'hFF, "R9 target reg in initiator role");
    rd(3'd3, "R2 target readback");
    wr(3'd2, 8'h40, "R9 switch to target role");
    wr(3'd2, 8'h00, "R9 back to initiator role");

    // R3/R4: reset command freezes state
    wr(3'd2, 8'h3C, "R4 mode before reset");
    wr(3'd1, 8'h81, "R3 reset command set");
    wr(3'd2, 8'hFF, "R4 mode write ignored during reset");
    rd(3'd2, "R4 mode reads zero during reset");
    wr(3'd1, 8'h9F, "R4 low cmd bits ignored during reset");
    rd(3'd1, "R4 cmd readback");
    clr_irq("R8 clear after reset irq");
    wr(3'd1, 8'h00, "R3 reset command released");

    // R5: busy loss with monitor on
    wr(3'd2, 8'h04, "R5 monitor on");
    wr(3'd1, 8'h1F, "R5 initiator drives on");
    bus_bsy_i = 1'b1; tick("R5 busy high");
    bus_bsy_i = 1'b0; tick("R5 busy dropped");
    rd(3'd1, "R5 cmd low bits stripped");
    clr_irq("R8 clear after busy loss");
    // R5: busy loss with monitor off
    wr(3'd2, 8'h00, "R5 monitor off");
    wr(3'd1, 8'h1F, "R5 drives on again");
    bus_bsy_i = 1'b1; tick("R5 busy high, no monitor");
    bus_bsy_i = 1'b0; tick("R5 busy dropped, no monitor");

    // R6: end of process
    dma_eop_i = 1'b1; tick("R6 eop disabled ignored");
    wr(3'd2, 8'h08, "R6 eop enable");
    dma_eop_i = 1'b1; tick("R6 eop raises irq");
    clr_irq("R8 clear after eop");

    // R7: parity combinations
    wr(3'd2, 8'h10, "R7 par irq en without check");
    par_err_i = 1'b1; tick("R7 parity ignored");
    wr(3'd2, 8'h20, "R7 check only");
    par_err_i = 1'b1; tick("R7 parity latched, no irq");
    wr(3'd2, 8'h30, "R7 check and irq");
    par_err_i = 1'b1; tick("R7 parity irq");
    // R8: set wins over clear in the same cycle
    par_err_i = 1'b1; host_irq_clr = 1'b1; tick("R8 set beats clear");
    clr_irq("R8 clear both latches");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      host_cs      = ($urandom % 3) == 0;
      host_we      = ($urandom % 2) == 0;
      host_addr    = 3'($urandom % 5);
      host_wdata   = 8'($urandom);
      if (($urandom % 8) != 0) host_wdata[7] = 1'b0;
      host_irq_clr = ($urandom % 10) == 0;
      dma_eop_i    = ($urandom % 8) == 0;
      par_err_i    = ($urandom % 6) == 0;
      if (($urandom % 10) == 0) bus_bsy_i = ~bus_bsy_i;
      tick("R1 R5 R7 R9 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule